// File: doc/BRIEF.md
# Counted FIFO Access Port

This block connects a 16-bit memory-mapped register bus to a pair of byte-wide packet FIFOs for one endpoint. Before sending a packet, software writes the packet's byte count into a count register. It then feeds the transmit FIFO through one of two data addresses. One address takes a full halfword per access. The other takes a single byte. The count that remains decides how many bytes each write deposits. This lets an odd-length packet be written entirely through the halfword address: the last access stores only its low byte. A DMA engine that can only repeat the same address therefore works without special handling.

The receive FIFO is filled one byte at a time by the link side, and software drains it through the same two addresses. A halfword read takes two bytes, or one byte when only one is left. A byte read takes exactly one byte. This lets the tail of a packet be collected byte by byte.

A status register reports three things: that the loaded packet has been fully written, a sticky overrun for writes beyond the count, and that the receive FIFO is empty. When the transmit FIFO has no room for a write, the bus is held with a ready signal and the write is not discarded.

Top module: `cnt_fifo_port`

## Requirements
- R1: A write to the halfword data port (byte offset 0) while the remaining count is two or more pushes `wdata[7:0]` and then `wdata[15:8]` into the transmit FIFO, and lowers the count by two.
- R2: A write to the byte data port pushes only `wdata[7:0]` and lowers the count by one.
- R3: While the remaining count is one, a write to either data port pushes only `wdata[7:0]` and the count becomes zero. A count of 5 followed by three halfword writes leaves exactly five bytes in the transmit FIFO.
- R4: The byte data port is at byte offset 4, four above the halfword port. The count register is at offset 8 and the status register is at offset 12. Reading the count register returns the remaining count.
- R5: A write to either data port while the count is zero pushes nothing and sets the overrun flag, status bit 1. The flag stays set until software writes status with bit 1 set.
- R6: The packet-done flag, status bit 0, sets in the cycle the count reaches zero through data writes. It clears when the count register is written.
- R7: When the transmit FIFO lacks room for the bytes a write would push, `bus_ready` is low and neither the count nor the FIFO changes. The write completes once room frees up, and no byte is lost or reordered.
- R8: A read of the byte data port pops one receive byte and returns it in bits 7:0, with bits 15:8 zero.
- R9: A read of the halfword data port pops two bytes, with the first byte in bits 7:0. If only one byte is present it pops that byte and returns zero in bits 15:8. A read while the FIFO is empty returns zero and pops nothing.
- R10: After reset the count is zero, the status reads 0x0004 (only the receive-empty flag, bit 2, is set), and `tx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access request, held until `bus_ready` |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while the access is selected |
| bus_ready | output | 1 | Low while a data write is stalled |
| tx_pop | input | 1 | Link side takes one transmit byte |
| tx_byte | output | 8 | Head byte of the transmit FIFO |
| tx_valid | output | 1 | Transmit FIFO holds at least one byte |
| rx_push | input | 1 | Link side offers one receive byte |
| rx_byte | input | 8 | Receive byte |
| rx_space | output | 1 | Receive FIFO can take a byte |

## Verification
The bench targets the odd-length tail. It loads a count of 5 and issues three halfword writes. A design that ignores the count pushes six bytes, and the scoreboard reports the extra one. It also switches to the byte port when one byte remains; a design that trims only halfword writes shows the wrong count there. Overrun is checked at zero count, where a design that still pushes produces an unexpected byte and a missing sticky flag. The bench then fills the transmit FIFO with the drain stopped. A design that drops or decrements during the stall loses bytes from the expected stream. On the read side, a halfword read with one byte left must return a zero upper byte. An over-eager pop would underflow the FIFO.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
   localparam int OFS_WORD  = 0;
   localparam int OFS_BYTE  = 4;
   localparam int OFS_COUNT = 8;
   localparam int OFS_STAT  = 12;

   localparam int ST_DONE  = 0;
   localparam int ST_OVR   = 1;
   localparam int ST_EMPTY = 2;

   localparam int BUS_W  = 16;
   localparam int LANES  = 2;
   localparam int LANE_W = 8;
endpackage

// File: rtl/cfp_lane_fifo.sv
module cfp_lane_fifo #(
   parameter int DEPTH = 8,
   parameter int LANES = 2,
   localparam int PW  = $clog2(DEPTH),
   localparam int LVW = PW + 1,
   localparam int LW  = $clog2(LANES + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LW-1:0]      in_n,
   input  logic [LANES*8-1:0] in_data,
   input  logic [LW-1:0]      out_n,
   output logic [LANES*8-1:0] out_data,
   output logic [LVW-1:0]     level,
   output logic [LVW-1:0]     free
);
   if (DEPTH < LANES || (1 << PW) != DEPTH) begin : g_bad_depth
      $error("cfp_lane_fifo: DEPTH must be a power of two not below LANES");
   end

   logic [7:0]    mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;

   assign free = LVW'(DEPTH) - level;

   always_ff @(posedge clk) begin
      for (int i = 0; i < LANES; i++) begin
         if (LW'(i) < in_n) mem[wr_ptr + PW'(i)] <= in_data[i*8 +: 8];
      end
   end

   for (genvar gi = 0; gi < LANES; gi++) begin : g_head
      assign out_data[gi*8 +: 8] = mem[rd_ptr + PW'(gi)];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         wr_ptr <= wr_ptr + PW'(in_n);
         rd_ptr <= rd_ptr + PW'(out_n);
         level  <= level + LVW'(in_n) - LVW'(out_n);
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      LVW'(in_n) <= free); // R7
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      LVW'(out_n) <= level); // R9
   AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> level == $past(level) + LVW'($past(in_n)) - LVW'($past(out_n))); // R3
endmodule

// File: rtl/cfp_tx_steer.sv
module cfp_tx_steer #(
   parameter int CNT_W = 16
) (
   input  logic [CNT_W-1:0] remain,
   input  logic             byte_sel,
   input  logic [15:0]      wdata,
   output logic [1:0]       push_n,
   output logic [15:0]      lanes
);
   always_comb begin
      if (remain == '0)                           push_n = 2'd0;
      else if (byte_sel || remain == CNT_W'(1))   push_n = 2'd1;
      else                                        push_n = 2'd2;
   end
   assign lanes = wdata;
endmodule

// File: rtl/cfp_rx_steer.sv
module cfp_rx_steer #(
   parameter int LVW = 4
) (
   input  logic [LVW-1:0] level,
   input  logic           byte_sel,
   input  logic [15:0]    head,
   output logic [1:0]     pop_n,
   output logic [15:0]    rdata
);
   always_comb begin
      if (level == '0)                          pop_n = 2'd0;
      else if (byte_sel || level == LVW'(1))    pop_n = 2'd1;
      else                                      pop_n = 2'd2;
      case (pop_n)
         2'd2:    rdata = head;
         2'd1:    rdata = {8'h00, head[7:0]};
         default: rdata = 16'h0000;
      endcase
   end
endmodule

// File: rtl/cnt_fifo_port.sv
module cnt_fifo_port #(
   parameter int ADDR_W   = 4,
   parameter int CNT_W    = 16,
   parameter int TX_DEPTH = 8,
   parameter int RX_DEPTH = 8,
   localparam int TLVW = $clog2(TX_DEPTH) + 1,
   localparam int RLVW = $clog2(RX_DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   output logic              bus_ready,
   input  logic              tx_pop,
   output logic [7:0]        tx_byte,
   output logic              tx_valid,
   input  logic              rx_push,
   input  logic [7:0]        rx_byte,
   output logic              rx_space
);
   import cfp_pkg::*;

   if (ADDR_W < 4 || CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_cfg
      $error("cnt_fifo_port: ADDR_W >= 4 and 2 <= CNT_W <= 16 required");
   end

   logic             hit_word, hit_byte, hit_cnt, hit_stat, data_hit;
   logic             wr_data, rd_data, cnt_wr, stat_wr;
   logic [CNT_W-1:0] cnt;
   logic             done, ovr;
   logic [1:0]       push_n, pop_n;
   logic [15:0]      tx_lanes, rx_head, rx_rd;
   logic [1:0]       tx_in_n, rx_out_n, tx_out_n, rx_in_n;
   logic [TLVW-1:0]  tx_level, tx_free;
   logic [RLVW-1:0]  rx_level, rx_free;
   logic [15:0]      tx_head;
   logic             stall;

   assign hit_word = bus_addr == ADDR_W'(OFS_WORD);
   assign hit_byte = bus_addr == ADDR_W'(OFS_BYTE);
   assign hit_cnt  = bus_addr == ADDR_W'(OFS_COUNT);
   assign hit_stat = bus_addr == ADDR_W'(OFS_STAT);
   assign data_hit = hit_word || hit_byte;

   assign wr_data = bus_sel && bus_wr && data_hit;
   assign rd_data = bus_sel && !bus_wr && data_hit;
   assign cnt_wr  = bus_sel && bus_wr && hit_cnt;
   assign stat_wr = bus_sel && bus_wr && hit_stat;

   cfp_tx_steer #(.CNT_W(CNT_W)) u_tx_steer (
      .remain(cnt), .byte_sel(hit_byte), .wdata(bus_wdata),
      .push_n(push_n), .lanes(tx_lanes));

   assign stall     = wr_data && (TLVW'(push_n) > tx_free);
   assign bus_ready = !stall;
   assign tx_in_n   = (wr_data && !stall) ? push_n : 2'd0;

   assign tx_valid = tx_level != '0;
   assign tx_byte  = tx_head[7:0];
   assign tx_out_n = (tx_pop && tx_valid) ? 2'd1 : 2'd0;

   cfp_lane_fifo #(.DEPTH(TX_DEPTH), .LANES(LANES)) u_tx_fifo (
      .clk(clk), .rst_n(rst_n), .in_n(tx_in_n), .in_data(tx_lanes),
      .out_n(tx_out_n), .out_data(tx_head), .level(tx_level), .free(tx_free));

   cfp_rx_steer #(.LVW(RLVW)) u_rx_steer (
      .level(rx_level), .byte_sel(hit_byte), .head(rx_head),
      .pop_n(pop_n), .rdata(rx_rd));

   assign rx_space = rx_free != '0;
   assign rx_in_n  = (rx_push && rx_space) ? 2'd1 : 2'd0;
   assign rx_out_n = rd_data ? pop_n : 2'd0;

   cfp_lane_fifo #(.DEPTH(RX_DEPTH), .LANES(LANES)) u_rx_fifo (
      .clk(clk), .rst_n(rst_n), .in_n(rx_in_n), .in_data({8'h00, rx_byte}),
      .out_n(rx_out_n), .out_data(rx_head), .level(rx_level), .free(rx_free));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
         ovr  <= 1'b0;
      end else begin
         if (cnt_wr) begin
            cnt  <= bus_wdata[CNT_W-1:0];
            done <= 1'b0;
         end else if (tx_in_n != 2'd0) begin
            cnt <= cnt - CNT_W'(tx_in_n);
            if (cnt == CNT_W'(tx_in_n)) done <= 1'b1;
         end
         if (wr_data && cnt == '0)               ovr <= 1'b1;
         else if (stat_wr && bus_wdata[ST_OVR])  ovr <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = 16'h0000;
      if (data_hit)     bus_rdata = rx_rd;
      else if (hit_cnt) bus_rdata = 16'(cnt);
      else if (hit_stat) begin
         bus_rdata[ST_DONE]  = done;
         bus_rdata[ST_OVR]   = ovr;
         bus_rdata[ST_EMPTY] = rx_level == '0;
      end
   end

   AST_WORD_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && hit_word && bus_ready && cnt >= CNT_W'(2))
      |=> cnt == $past(cnt) - CNT_W'(2)); // R1
   AST_BYTE_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && hit_byte && bus_ready && cnt != '0)
      |=> cnt == $past(cnt) - CNT_W'(1)); // R2
   AST_LAST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && bus_ready && cnt == CNT_W'(1))
      |=> cnt == '0 && tx_level == $past(tx_level) + TLVW'(1) - TLVW'($past(tx_out_n))); // R3
   AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && cnt == '0) |=> ovr); // R5
   AST_DONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cnt == '0); // R6
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && !bus_ready) |=> cnt == $past(cnt)); // R7
endmodule

// File: tb/cnt_fifo_port_test.sv
module cnt_fifo_port_test;
   localparam int PERIOD = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_sel = 0, bus_wr = 0;
   logic [3:0] bus_addr = 0;
   logic [15:0] bus_wdata = 0, bus_rdata;
   logic bus_ready, tx_pop = 0, tx_valid, rx_push = 0, rx_space;
   logic [7:0] tx_byte, rx_byte = 0;

   int checks = 0, errors = 0;
   logic drain_en = 1'b1;
   logic [7:0] sb_q[$];
   string      sb_tag[$];
   logic [15:0] rd;

   always #(PERIOD/2) clk = ~clk;

   cnt_fifo_port uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ready(bus_ready), .tx_pop(tx_pop), .tx_byte(tx_byte),
      .tx_valid(tx_valid), .rx_push(rx_push), .rx_byte(rx_byte),
      .rx_space(rx_space));

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic expect_tx(input logic [7:0] b, input string req);
      sb_q.push_back(b);
      sb_tag.push_back(req);
   endtask

   // monitor: compare each byte leaving the transmit FIFO with the scoreboard
   always @(negedge clk) begin
      tx_pop = 1'b0;
      if (rst_n && drain_en && tx_valid) begin
         checks++;
         if (sb_q.size() == 0) begin
            errors++;
            $display("FAIL R5: actual unexpected byte %h expected none", tx_byte);
         end else begin
            logic [7:0] e;
            string t;
            e = sb_q.pop_front();
            t = sb_tag.pop_front();
            if (tx_byte !== e) begin
               errors++;
               $display("FAIL %s: actual %h expected %h", t, tx_byte, e);
            end
         end
         tx_pop = 1'b1;
      end
   end

   task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      #1;
      while (!bus_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 0;
   endtask

   task automatic link_push(input logic [7:0] b);
      @(negedge clk);
      rx_push = 1; rx_byte = b;
      @(negedge clk);
      rx_push = 0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check("R10 tx_valid", {15'd0, tx_valid}, 16'h0000);
      bus_read(4'd12, rd); check("R10 status", rd, 16'h0004);
      bus_read(4'd8, rd);  check("R10 count", rd, 16'h0000);

      // R3 odd count through halfword port only
      bus_write(4'd8, 16'd5);
      expect_tx(8'h11, "R1"); expect_tx(8'h22, "R1");
      expect_tx(8'h33, "R1"); expect_tx(8'h44, "R1");
      expect_tx(8'h55, "R3");
      bus_write(4'd0, 16'h2211);
      bus_write(4'd0, 16'h4433);
      bus_write(4'd0, 16'h6655);
      bus_read(4'd8, rd);  check("R3 count zero", rd, 16'h0000);
      bus_read(4'd12, rd); check("R6 done set", rd, 16'h0005);
      repeat (10) @(negedge clk);
      check("R3 five bytes only", 16'(sb_q.size()), 16'h0000);

      // R2/R4 byte port, R6 clear on load, R3 via byte port
      bus_write(4'd8, 16'd4);
      bus_read(4'd12, rd); check("R6 done cleared", rd, 16'h0004);
      expect_tx(8'h77, "R2");
      bus_write(4'd4, 16'hAB77);
      bus_read(4'd8, rd);  check("R2 R4 count after byte", rd, 16'h0003);
      expect_tx(8'h88, "R1"); expect_tx(8'h99, "R1");
      bus_write(4'd0, 16'h9988);
      bus_read(4'd8, rd);  check("R1 count after word", rd, 16'h0001);
      expect_tx(8'hEF, "R3");
      bus_write(4'd4, 16'hCDEF);
      bus_read(4'd8, rd);  check("R3 count after last byte", rd, 16'h0000);

      // R5 overrun
      repeat (6) @(negedge clk);
      bus_write(4'd0, 16'h1234);
      bus_write(4'd4, 16'h5678);
      repeat (6) @(negedge clk);
      check("R5 nothing pushed", 16'(sb_q.size()) | {15'd0, tx_valid}, 16'h0000);
      bus_read(4'd12, rd); check("R5 overrun set", rd, 16'h0007);
      bus_write(4'd12, 16'h0000);
      bus_read(4'd12, rd); check("R5 overrun sticky", rd, 16'h0007);
      bus_write(4'd12, 16'h0002);
      bus_read(4'd12, rd); check("R5 overrun cleared", rd, 16'h0005);

      // R7 stall when transmit FIFO is full
      drain_en = 1'b0;
      bus_write(4'd8, 16'd12);
      for (int i = 0; i < 12; i++) expect_tx(8'(i + 1), "R7");
      fork
         begin
            for (int i = 0; i < 6; i++)
               bus_write(4'd0, {8'(2*i + 2), 8'(2*i + 1)});
         end
         begin
            repeat (12) @(negedge clk);
            #1 check("R7 ready low when full", {15'd0, bus_ready}, 16'h0000);
            drain_en = 1'b1;
         end
      join
      repeat (20) @(negedge clk);
      check("R7 all bytes delivered", 16'(sb_q.size()), 16'h0000);
      bus_read(4'd8, rd);  check("R7 count zero", rd, 16'h0000);

      // R8 R9 receive side
      link_push(8'hA1); link_push(8'hB2); link_push(8'hC3);
      bus_read(4'd0, rd);  check("R9 word read", rd, 16'hB2A1);
      bus_read(4'd4, rd);  check("R8 byte read", rd, 16'h00C3);
      bus_read(4'd12, rd); check("R8 rx empty", rd & 16'h0004, 16'h0004);
      bus_read(4'd0, rd);  check("R9 empty read", rd, 16'h0000);
      link_push(8'hD4);
      bus_read(4'd0, rd);  check("R9 single byte left", rd, 16'h00D4);
      bus_read(4'd12, rd); check("R9 no overpop", rd & 16'h0004, 16'h0004);

      finish_run();
   end
endmodule